// File: doc/BRIEF.md
# Selectable Clock Post-Divider with Glitch-Free Enable

This block takes a fast oscillator-rate clock and produces a slower clock from it, divided by one of four ratios picked with a 2-bit code. The result comes out as a complementary pair: a true output and its exact inverse. Every ratio gives a 50% duty cycle, divide-by-one included, where the true output is the input clock passed through a clean gate.

An active-high enable input turns the pair on and off. The enable is resynchronised to the input clock, and it is applied only where the divided waveform has just fallen. So turning the output on or off never cuts a pulse short. While disabled, the true output rests low and the complement rests high. The ratio code comes from a configuration block elsewhere. A new code is adopted at the same falling point, which restarts the divided phase. No signal crosses the edge with a handshake: ratio, enable and outputs are plain level pins.

Top module: `clk_post_divider`

## Requirements
- R1: The ratio code selects the division: code 2'b00 divides by 2, 2'b01 by 4, 2'b10 by 8 and 2'b11 by 1. In steady state, one output period lasts that many input clock periods.
- R2: The high and low phases of the true output are equal in steady state: N/2 input periods each for N of 2, 4 and 8, and one input half-period each for divide-by-one.
- R3: The complement output is always the logical inverse of the true output.
- R4: While reset is asserted, and after it until the enable has been seen, the true output is low and the complement is high.
- R5: Once the enable has been low long enough to pass the synchroniser and one divided period, the true output stays low and the complement stays high.
- R6: Removing the enable never shortens a high phase. The last high phase lasts the full half-period of the active ratio.
- R7: Asserting the enable starts the output at a phase boundary. The output shows a low phase at least one half-period long, then a full-width high phase.
- R8: A new ratio code is adopted only where the divided output falls, and the phase restarts there. No high or low phase across the change is shorter than the smaller of the old and new half-periods.
- R9: The enable passes through a synchroniser of SYNC_STAGES flops on the input clock. The output cannot start within SYNC_STAGES input cycles of the enable rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_sel | input | 2 | Ratio code (00:/2, 01:/4, 10:/8, 11:/1) |
| out_en | input | 1 | Output enable, active high, asynchronous to nothing but sampled on clk_vco |
| clk_out_p | output | 1 | Divided clock, true polarity |
| clk_out_n | output | 1 | Divided clock, complement polarity |

## Verification
A counter that misses its boundary, or a ratio register loaded at the wrong moment, shows at the pins as a high or low phase of the wrong length. This appears within one output period, at most eight input cycles. A run flag updated outside the boundary shows as a shortened first or last pulse around an enable change. A stuck divide-by-one gate shows as pulses while the output should be parked. The directed scenarios measure the length of every phase at half-cycle resolution, so each of these faults is caught in the period where it occurs.

// File: rtl/clk_post_divider_pkg.sv
package clk_post_divider_pkg;

  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    RATIO_D2 = 2'b00,
    RATIO_D4 = 2'b01,
    RATIO_D8 = 2'b10,
    RATIO_D1 = 2'b11
  } ratio_e;

  // counter bit that carries the divided waveform for a ratio
  function automatic int tap_idx(input ratio_e r);
    case (r)
      RATIO_D2: tap_idx = 0;
      RATIO_D4: tap_idx = 1;
      RATIO_D8: tap_idx = 2;
      default:  tap_idx = 0;
    endcase
  endfunction

  // low counter bits that are all ones in the last cycle of a period
  function automatic logic [CNT_W-1:0] lsb_mask(input ratio_e r);
    lsb_mask = CNT_W'((32'd1 << (tap_idx(r) + 1)) - 32'd1);
  endfunction

  // half-period in input cycles, zero for the pass-through ratio
  function automatic int half_cycles(input ratio_e r);
    half_cycles = (r == RATIO_D1) ? 0 : (1 << tap_idx(r));
  endfunction

endpackage

// File: rtl/clk_post_divider_en_sync.sv
module clk_post_divider_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_async,
  output logic en_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= en_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign en_sync = chain_q[STAGES-1];

endmodule

// File: rtl/clk_post_divider_phase.sv
module clk_post_divider_phase
  import clk_post_divider_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  input  logic       en_sync,
  output ratio_e     ratio_q,
  output logic       run_q,
  output logic       div_q
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  ratio_e           ratio_d;
  logic             run_d;
  logic             div_d;
  logic             at_edge;
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask    = lsb_mask(ratio_q);
    // phase boundary: the cycle in which the divided output falls
    at_edge = (ratio_q == RATIO_D1) || ((cnt_q & mask) == mask);
    ratio_d = at_edge ? ratio_e'(ratio_sel) : ratio_q;
    run_d   = at_edge ? en_sync : run_q;
    cnt_d   = at_edge ? '0 : cnt_q + 1'b1;
    div_d   = run_d && (ratio_d != RATIO_D1) && cnt_d[tap_idx(ratio_d)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_D2;
      run_q   <= 1'b0;
      div_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      run_q   <= run_d;
      div_q   <= div_d;
    end
  end

endmodule

// File: rtl/clk_post_divider_out.sv
module clk_post_divider_out
  import clk_post_divider_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_e ratio_q,
  input  logic   run_q,
  input  logic   div_q,
  output logic   gate_q,
  output logic   out_p,
  output logic   out_n
);

  // pass-through gate changes only while the input clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= run_q && (ratio_q == RATIO_D1);
  end

  assign out_p = div_q | (clk & gate_q);
  assign out_n = ~out_p;

endmodule

// File: rtl/clk_post_divider.sv
module clk_post_divider
  import clk_post_divider_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_vco,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  input  logic       out_en,
  output logic       clk_out_p,
  output logic       clk_out_n
);

  logic   en_sync;
  ratio_e ratio_q;
  logic   run_q;
  logic   div_q;
  logic   gate_q;

  clk_post_divider_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_vco),
    .rst_n    (rst_n),
    .en_async (out_en),
    .en_sync  (en_sync)
  );

  clk_post_divider_phase u_phase (
    .clk       (clk_vco),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .en_sync   (en_sync),
    .ratio_q   (ratio_q),
    .run_q     (run_q),
    .div_q     (div_q)
  );

  clk_post_divider_out u_out (
    .clk     (clk_vco),
    .rst_n   (rst_n),
    .ratio_q (ratio_q),
    .run_q   (run_q),
    .div_q   (div_q),
    .gate_q  (gate_q),
    .out_p   (clk_out_p),
    .out_n   (clk_out_n)
  );

endmodule

// File: rtl/clk_post_divider_chk.sv
module clk_post_divider_chk
  import clk_post_divider_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input ratio_e ratio_q,
  input logic   run_q,
  input logic   en_sync,
  input logic   div_q,
  input logic   gate_q,
  input logic   clk_out_p,
  input logic   clk_out_n
);

  localparam int IDLE_LIM = (1 << CNT_W) + 2;

  logic [4:0]     idle_cnt;
  logic [CNT_W:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      hi_len   <= '0;
    end else begin
      if (en_sync)                   idle_cnt <= '0;
      else if (idle_cnt != IDLE_LIM) idle_cnt <= idle_cnt + 1'b1;
      hi_len <= div_q ? hi_len + 1'b1 : '0;
    end
  end

  // R3
  comp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out_n == ~clk_out_p);

  // R5
  park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt == IDLE_LIM) |-> (!div_q && !gate_q));

  // R6
  full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_q) && $past(ratio_q) != RATIO_D1)
      |-> (hi_len == (CNT_W+1)'(half_cycles($past(ratio_q)))));

  // R9
  start_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(en_sync));

  // R9
  stop_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> !$past(en_sync));

endmodule

bind clk_post_divider clk_post_divider_chk u_chk (
  .clk       (clk_vco),
  .rst_n     (rst_n),
  .ratio_q   (ratio_q),
  .run_q     (run_q),
  .en_sync   (en_sync),
  .div_q     (div_q),
  .gate_q    (gate_q),
  .clk_out_p (clk_out_p),
  .clk_out_n (clk_out_n)
);

// File: tb/clk_post_divider_test.sv
`timescale 1ns/1ps
module clk_post_divider_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ratio_sel = 2'b00;
  logic       out_en = 1'b0;
  logic       clk_out_p, clk_out_n;

  int n_chk = 0;
  int n_bad = 0;

  // phase monitor, lengths counted in input half-cycles
  logic cur_lvl = 1'b0;
  int   cur_len = 0;
  int   last_hi = 0, last_lo = 0;
  int   min_hi = 1000, min_lo = 1000;
  int   rises = 0;
  int   pair_bad = 0;

  always #2.5 clk = ~clk;

  clk_post_divider uut (
    .clk_vco   (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .out_en    (out_en),
    .clk_out_p (clk_out_p),
    .clk_out_n (clk_out_n)
  );

  always @(clk) begin
    #1;
    if (clk_out_n !== ~clk_out_p) pair_bad++;
    if (clk_out_p === cur_lvl) cur_len++;
    else begin
      if (cur_lvl) begin
        last_hi = cur_len;
        if (cur_len < min_hi) min_hi = cur_len;
      end else begin
        last_lo = cur_len;
        if (cur_len < min_lo) min_lo = cur_len;
        rises++;
      end
      cur_lvl = clk_out_p;
      cur_len = 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [1:0] code);
    case (code)
      2'b00: ratio_of = 2;
      2'b01: ratio_of = 4;
      2'b10: ratio_of = 8;
      default: ratio_of = 1;
    endcase
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_rises(input int count);
    int target = rises + count;
    while (rises < target) @(posedge clk);
    #1;
  endtask

  task automatic wait_low();
    while (clk_out_p !== 1'b0) @(clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    out_en = 1'b0;
    cyc(4);
    check(clk_out_p === 1'b0, "R4 p in reset", int'(clk_out_p), 0);
    check(clk_out_n === 1'b1, "R4 n in reset", int'(clk_out_n), 1);
    rst_n = 1'b1;
    begin
      int r0 = rises;
      cyc(20);
      check(rises == r0 && clk_out_p === 1'b0, "R4 quiet after reset", rises - r0, 0);
    end
  endtask

  task automatic t_ratio(input logic [1:0] code);
    int n = ratio_of(code);
    ratio_sel = code;
    out_en = 1'b1;
    cyc(30);
    wait_rises(2);
    check(last_hi + last_lo == 2 * n, "R1 period", last_hi + last_lo, 2 * n);
    check(last_hi == n && last_lo == n, "R2 duty", last_hi, last_lo);
  endtask

  task automatic t_disable(input logic [1:0] code);
    int n = ratio_of(code);
    int r0;
    ratio_sel = code;
    out_en = 1'b1;
    cyc(30);
    wait_rises(1);
    min_hi = 1000;
    out_en = 1'b0;
    cyc(30);
    check(min_hi >= n, "R6 last high full", min_hi, n);
    r0 = rises;
    cyc(20);
    check(rises == r0, "R5 parked no rise", rises - r0, 0);
    check(clk_out_p === 1'b0 && clk_out_n === 1'b1, "R5 park level", int'(clk_out_p), 0);
  endtask

  task automatic t_enable(input logic [1:0] code);
    int n = ratio_of(code);
    ratio_sel = code;
    out_en = 1'b0;
    cyc(30);
    out_en = 1'b1;
    wait_rises(1);
    check(last_lo >= n, "R7 low before start", last_lo, n);
    wait_low();
    check(last_hi == n, "R7 first high full", last_hi, n);
  endtask

  task automatic t_switch(input logic [1:0] from, input logic [1:0] to);
    int a = ratio_of(from);
    int b = ratio_of(to);
    int m = (a < b) ? a : b;
    ratio_sel = from;
    out_en = 1'b1;
    cyc(30);
    wait_rises(1);
    cyc(1);
    min_hi = 1000;
    min_lo = 1000;
    ratio_sel = to;
    cyc(40);
    check(min_hi >= m, "R8 high across change", min_hi, m);
    check(min_lo >= m, "R8 low across change", min_lo, m);
    wait_rises(2);
    check(last_hi == b && last_lo == b, "R8 new ratio", last_hi, b);
  endtask

  task automatic t_sync();
    int r0;
    ratio_sel = 2'b00;
    out_en = 1'b0;
    cyc(30);
    r0 = rises;
    out_en = 1'b1;
    cyc(2);
    check(rises == r0 && clk_out_p === 1'b0, "R9 synchroniser delay", rises - r0, 0);
    cyc(10);
    check(rises > r0, "R9 start after sync", rises - r0, 1);
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ratio(2'b00);
    t_ratio(2'b01);
    t_ratio(2'b10);
    t_ratio(2'b11);
    t_disable(2'b10);
    t_disable(2'b11);
    t_disable(2'b01);
    t_enable(2'b10);
    t_enable(2'b11);
    t_switch(2'b10, 2'b00);
    t_switch(2'b00, 2'b10);
    t_switch(2'b01, 2'b11);
    t_switch(2'b11, 2'b00);
    t_sync();
    check(pair_bad == 0, "R3 complement", pair_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule